// File: doc/BRIEF.md
# Peripheral Attention Flag Scanner

This block gathers "ready for a new command" indications from a bank of peripheral controllers and tells the control processor which controller to serve next. Each controller pulses its attention input when it has progressed far enough through an operation to take another command; the scanner latches that pulse as a flag and holds it until the processor acknowledges service. The flag bank is summarised twice: one master bit that says whether anything at all is waiting, and one bit per group of controllers. Controllers are grouped by data rate. The fastest, drum-like devices sit in group 0, tape-like devices in group 1, and slower devices in the later groups. The winner is chosen by first finding the highest-priority group with a pending flag, then the highest-priority controller inside that group.

Errors are reported in a deferred way. When a controller detects a fault it sets its own per-controller error flag. It may also set one or more bits in a shared error-class register, which any controller can write. Nothing is signalled at once. The per-controller flag is examined only when the processor next issues a block start or end command to that controller. At that moment the error-hit output tells the processor to divert to its error handler, and the flag is consumed. The error-class bits stay visible until software clears them bit by bit.

Top module: `attn_scanner`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, every attention flag, every per-controller error flag and every error-class bit is zero. As a result master_any, group_any, win_valid, win_idx and error_hit all read zero.
- R2: A high bit i on att_set sets attention flag i at the next clock edge. The flag then stays set until it is acknowledged.
- R3: master_any is high exactly when at least one attention flag is set. group_any[g] is high exactly when a flag is set among controllers g*GROUP_SIZE to g*GROUP_SIZE+GROUP_SIZE-1.
- R4: win_valid equals master_any. When win_valid is high, win_idx is the lowest-numbered pending controller: lower group numbers win over higher ones, and inside a group lower positions win.
- R5: With ack_valid high, the flag of controller ack_idx is cleared at the next edge. If att_set carries the same controller in that cycle, the flag stays set. With ack_valid low, ack_idx has no effect.
- R6: A high bit i on err_set sets the error flag of controller i at the next edge. error_hit equals cmd_valid AND the error flag of controller cmd_idx, combinationally in the same cycle. It stays low whenever no command is presented.
- R7: A command (cmd_valid high) to controller k clears the error flag of k at the next edge. If err_set bit k is high in the same cycle, the flag stays set. Commands to other controllers leave the flag of k unchanged.
- R8: A high bit c on etype_set sets error-class bit c at the next edge. A high bit c on etype_clr clears it, and a set in the same cycle wins over the clear. err_class shows the register.
- R9: Error inputs and commands never change attention flags, master_any, group_any or the winner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| att_set | input | NUM_CTRL | Per-controller attention set pulses |
| ack_valid | input | 1 | Service acknowledge strobe |
| ack_idx | input | IDX_W | Controller being acknowledged |
| err_set | input | NUM_CTRL | Per-controller error detect pulses |
| etype_set | input | NUM_ETYPES | Error-class set pulses, shared by all controllers |
| etype_clr | input | NUM_ETYPES | Error-class clear pulses |
| cmd_valid | input | 1 | Block start/end command strobe |
| cmd_idx | input | IDX_W | Controller addressed by the command |
| master_any | output | 1 | Any attention flag pending |
| group_any | output | NUM_GROUPS | Per-group pending summary |
| win_valid | output | 1 | Winner index is meaningful |
| win_idx | output | IDX_W | Highest-priority pending controller |
| error_hit | output | 1 | Addressed controller has a stored error |
| err_class | output | NUM_ETYPES | Shared error-class register |

## Verification
A corrupted attention flag appears on master_any, group_any and the winner in the very next cycle after the edge that stored it, so every cycle is compared against a behavioural reference. A wrong per-controller error flag is latent by design: it only shows on error_hit when a command reaches that controller. The stimulus therefore sweeps commands across every controller index, including cycles where no error is stored. Set-versus-clear collisions on attention, controller error and error-class bits are driven on purpose, because a reversed precedence leaves no trace until that exact coincidence occurs.

// File: rtl/attn_pkg.sv
package attn_pkg;
    localparam int unsigned DEF_GROUPS     = 4;
    localparam int unsigned DEF_GROUP_SIZE = 4;
    localparam int unsigned DEF_ETYPES     = 4;

    typedef enum logic [1:0] {
        RATE_DRUM  = 2'd0,
        RATE_TAPE  = 2'd1,
        RATE_PRINT = 2'd2,
        RATE_SLOW  = 2'd3
    } rate_class_e;

    typedef struct packed {
        logic valid;
        logic [7:0] idx;
    } pick_t;

    function automatic rate_class_e group_rate(input int unsigned g);
        case (g)
            0:       return RATE_DRUM;
            1:       return RATE_TAPE;
            2:       return RATE_PRINT;
            default: return RATE_SLOW;
        endcase
    endfunction
endpackage

// File: rtl/attn_flag_bank.sv
module attn_flag_bank #(
    parameter int unsigned NUM_CTRL = 16,
    localparam int unsigned IDX_W = $clog2(NUM_CTRL)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_CTRL-1:0] att_set,
    input  logic                ack_valid,
    input  logic [IDX_W-1:0]    ack_idx,
    output logic [NUM_CTRL-1:0] flags
);
    logic [NUM_CTRL-1:0] ack_mask;

    always_comb begin
        ack_mask = '0;
        if (ack_valid) ack_mask[ack_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (flags & ~ack_mask) | att_set;
    end

    a_r2_set_sticks: assert property (@(posedge clk) disable iff (rst)
        (|att_set) |=> ((flags & $past(att_set)) == $past(att_set)));
    a_r5_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && !att_set[ack_idx]) |=> !flags[$past(ack_idx)]);
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (!ack_valid && att_set == '0) |=> $stable(flags));
endmodule

// File: rtl/attn_group_summary.sv
module attn_group_summary #(
    parameter int unsigned NUM_GROUPS = 4,
    parameter int unsigned GROUP_SIZE = 4,
    localparam int unsigned NUM_CTRL = NUM_GROUPS * GROUP_SIZE
) (
    input  logic [NUM_CTRL-1:0]   flags,
    output logic [NUM_GROUPS-1:0] group_any,
    output logic                  master_any
);
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        assign group_any[g] = |flags[g*GROUP_SIZE +: GROUP_SIZE];
    end
    assign master_any = |group_any;
endmodule

// File: rtl/attn_prio_pick.sv
module attn_prio_pick #(
    parameter int unsigned NUM_GROUPS = 4,
    parameter int unsigned GROUP_SIZE = 4,
    localparam int unsigned NUM_CTRL = NUM_GROUPS * GROUP_SIZE,
    localparam int unsigned IDX_W = $clog2(NUM_CTRL),
    localparam int unsigned GRP_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
    localparam int unsigned POS_W = (GROUP_SIZE > 1) ? $clog2(GROUP_SIZE) : 1
) (
    input  logic [NUM_CTRL-1:0]   flags,
    input  logic [NUM_GROUPS-1:0] group_any,
    output logic                  win_valid,
    output logic [IDX_W-1:0]      win_idx
);
    logic [POS_W-1:0] pos_in_grp [NUM_GROUPS];
    logic [GRP_W-1:0] grp_sel;
    logic             any_sel;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_local
        always_comb begin
            pos_in_grp[g] = '0;
            for (int p = GROUP_SIZE - 1; p >= 0; p--) begin
                if (flags[g*GROUP_SIZE + p]) pos_in_grp[g] = POS_W'(p);
            end
        end
    end

    always_comb begin
        grp_sel = '0;
        any_sel = 1'b0;
        for (int g = NUM_GROUPS - 1; g >= 0; g--) begin
            if (group_any[g]) begin
                grp_sel = GRP_W'(g);
                any_sel = 1'b1;
            end
        end
    end

    assign win_valid = any_sel;
    assign win_idx   = any_sel ? IDX_W'(grp_sel * GROUP_SIZE + pos_in_grp[grp_sel]) : '0;

    always_comb begin
        if (win_valid) a_r4_win_pending: assert (flags[win_idx]);
        if (win_valid) a_r4_none_lower: assert ((flags & ((NUM_CTRL'(1) << win_idx) - NUM_CTRL'(1))) == '0);
    end
endmodule

// File: rtl/attn_err_tracker.sv
module attn_err_tracker #(
    parameter int unsigned NUM_CTRL   = 16,
    parameter int unsigned NUM_ETYPES = 4,
    localparam int unsigned IDX_W = $clog2(NUM_CTRL)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_CTRL-1:0]   err_set,
    input  logic [NUM_ETYPES-1:0] etype_set,
    input  logic [NUM_ETYPES-1:0] etype_clr,
    input  logic                  cmd_valid,
    input  logic [IDX_W-1:0]      cmd_idx,
    output logic                  error_hit,
    output logic [NUM_ETYPES-1:0] err_class
);
    logic [NUM_CTRL-1:0] ctrl_err;
    logic [NUM_CTRL-1:0] consume;

    always_comb begin
        consume = '0;
        if (cmd_valid) consume[cmd_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_err  <= '0;
            err_class <= '0;
        end else begin
            ctrl_err  <= (ctrl_err & ~consume) | err_set;
            err_class <= (err_class & ~etype_clr) | etype_set;
        end
    end

    assign error_hit = cmd_valid & ctrl_err[cmd_idx];

    a_r6_hit_needs_cmd: assert property (@(posedge clk) disable iff (rst)
        error_hit |-> cmd_valid);
    a_r6_err_sticks: assert property (@(posedge clk) disable iff (rst)
        (|err_set) |=> ((ctrl_err & $past(err_set)) == $past(err_set)));
    a_r7_consumed: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !err_set[cmd_idx]) |=> !ctrl_err[$past(cmd_idx)]);
    a_r8_class_set_wins: assert property (@(posedge clk) disable iff (rst)
        (|etype_set) |=> ((err_class & $past(etype_set)) == $past(etype_set)));
endmodule

// File: rtl/attn_scanner.sv
module attn_scanner
    import attn_pkg::*;
#(
    parameter int unsigned NUM_GROUPS = DEF_GROUPS,
    parameter int unsigned GROUP_SIZE = DEF_GROUP_SIZE,
    parameter int unsigned NUM_ETYPES = DEF_ETYPES,
    localparam int unsigned NUM_CTRL = NUM_GROUPS * GROUP_SIZE,
    localparam int unsigned IDX_W = $clog2(NUM_CTRL)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_CTRL-1:0]   att_set,
    input  logic                  ack_valid,
    input  logic [IDX_W-1:0]      ack_idx,
    input  logic [NUM_CTRL-1:0]   err_set,
    input  logic [NUM_ETYPES-1:0] etype_set,
    input  logic [NUM_ETYPES-1:0] etype_clr,
    input  logic                  cmd_valid,
    input  logic [IDX_W-1:0]      cmd_idx,
    output logic                  master_any,
    output logic [NUM_GROUPS-1:0] group_any,
    output logic                  win_valid,
    output logic [IDX_W-1:0]      win_idx,
    output logic                  error_hit,
    output logic [NUM_ETYPES-1:0] err_class
);
    logic [NUM_CTRL-1:0] flags;

    attn_flag_bank #(.NUM_CTRL(NUM_CTRL)) u_bank (
        .clk(clk), .rst(rst), .att_set(att_set),
        .ack_valid(ack_valid), .ack_idx(ack_idx), .flags(flags)
    );

    attn_group_summary #(.NUM_GROUPS(NUM_GROUPS), .GROUP_SIZE(GROUP_SIZE)) u_sum (
        .flags(flags), .group_any(group_any), .master_any(master_any)
    );

    attn_prio_pick #(.NUM_GROUPS(NUM_GROUPS), .GROUP_SIZE(GROUP_SIZE)) u_pick (
        .flags(flags), .group_any(group_any),
        .win_valid(win_valid), .win_idx(win_idx)
    );

    attn_err_tracker #(.NUM_CTRL(NUM_CTRL), .NUM_ETYPES(NUM_ETYPES)) u_err (
        .clk(clk), .rst(rst), .err_set(err_set), .etype_set(etype_set),
        .etype_clr(etype_clr), .cmd_valid(cmd_valid), .cmd_idx(cmd_idx),
        .error_hit(error_hit), .err_class(err_class)
    );

    a_r3_master_tracks_flags: assert property (@(posedge clk) disable iff (rst)
        master_any == (flags != '0));
    a_r4_valid_is_master: assert property (@(posedge clk) disable iff (rst)
        win_valid == master_any);
    a_r9_errors_leave_flags: assert property (@(posedge clk) disable iff (rst)
        (!ack_valid && att_set == '0 && (cmd_valid || err_set != '0)) |=> $stable(win_idx));
endmodule

// File: tb/attn_scanner_tb.sv
`timescale 1ns/1ps
module attn_scanner_tb;
    localparam int NC = 16;
    localparam int NG = 4;
    localparam int GS = 4;
    localparam int NE = 4;

    logic clk = 1'b0;
    logic rst;
    logic [NC-1:0] att_set, err_set;
    logic ack_valid, cmd_valid;
    logic [3:0] ack_idx, cmd_idx;
    logic [NE-1:0] etype_set, etype_clr;
    logic master_any, win_valid, error_hit;
    logic [NG-1:0] group_any;
    logic [3:0] win_idx;
    logic [NE-1:0] err_class;

    int total = 0;
    int bad = 0;

    bit m_att [NC];
    bit m_err [NC];
    bit m_cls [NE];

    always #2.5 clk = ~clk;

    attn_scanner u_dut (
        .clk(clk), .rst(rst), .att_set(att_set), .ack_valid(ack_valid),
        .ack_idx(ack_idx), .err_set(err_set), .etype_set(etype_set),
        .etype_clr(etype_clr), .cmd_valid(cmd_valid), .cmd_idx(cmd_idx),
        .master_any(master_any), .group_any(group_any), .win_valid(win_valid),
        .win_idx(win_idx), .error_hit(error_hit), .err_class(err_class)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle();
        att_set = '0; err_set = '0; ack_valid = 0; ack_idx = '0;
        cmd_valid = 0; cmd_idx = '0; etype_set = '0; etype_clr = '0;
    endtask

    // Compare outputs (inputs already driven), then advance model and clock.
    task automatic step(input string tag);
        int exp_win, exp_master, exp_grp, exp_cls, exp_hit;
        #1;
        exp_win = -1; exp_master = 0; exp_grp = 0; exp_cls = 0;
        for (int i = NC - 1; i >= 0; i--) if (m_att[i]) exp_win = i;
        for (int i = 0; i < NC; i++) if (m_att[i]) begin
            exp_master = 1; exp_grp |= (1 << (i / GS));
        end
        for (int c = 0; c < NE; c++) if (m_cls[c]) exp_cls |= (1 << c);
        exp_hit = cmd_valid && m_err[cmd_idx];
        chk({tag, " R3 master"}, master_any, exp_master);
        chk({tag, " R3 group"}, group_any, exp_grp);
        chk({tag, " R4 valid"}, win_valid, exp_win >= 0);
        if (exp_win >= 0) chk({tag, " R4 winner"}, win_idx, exp_win);
        chk({tag, " R6 error_hit"}, error_hit, exp_hit);
        chk({tag, " R8 class"}, err_class, exp_cls);
        if (rst) begin
            for (int i = 0; i < NC; i++) begin m_att[i] = 0; m_err[i] = 0; end
            for (int c = 0; c < NE; c++) m_cls[c] = 0;
        end else begin
            if (ack_valid) m_att[ack_idx] = 0;
            for (int i = 0; i < NC; i++) if (att_set[i]) m_att[i] = 1;
            if (cmd_valid) m_err[cmd_idx] = 0;
            for (int i = 0; i < NC; i++) if (err_set[i]) m_err[i] = 1;
            for (int c = 0; c < NE; c++) begin
                if (etype_clr[c]) m_cls[c] = 0;
                if (etype_set[c]) m_cls[c] = 1;
            end
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #400000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle();
        rst = 1;
        for (int i = 0; i < NC; i++) begin m_att[i] = 0; m_err[i] = 0; end
        for (int c = 0; c < NE; c++) m_cls[c] = 0;
        @(negedge clk);
        att_set = '1; err_set = '1; etype_set = '1;   // R1: ignored under reset
        step("R1 in reset");
        idle(); step("R1 in reset");
        rst = 0;
        step("R1 after reset");
        chk("R1 master zero", master_any, 0);

        // R2/R3: single flag in a slow group
        att_set = 16'h0100; step("R2 set");
        idle(); step("R2 hold");
        chk("R2 flag held group2", group_any, 4'b0100);

        // R4: simultaneous flags, drain by acknowledging the winner
        att_set = 16'hA5A5; step("R4 burst");
        idle();
        for (int n = 0; n < 10; n++) begin
            ack_valid = win_valid; ack_idx = win_idx;
            step("R4 drain");
        end
        idle(); step("R4 drained");
        chk("R4 all served", master_any, 0);

        // R5: set and ack of the same controller together, set wins
        att_set = 16'h0020; ack_valid = 1; ack_idx = 4'd5; step("R5 collide");
        idle(); step("R5 after");
        chk("R5 set wins", win_idx, 5);
        ack_valid = 0; ack_idx = 4'd5; step("R5 ack ignored");
        chk("R5 still pending", master_any, 1);
        ack_valid = 1; ack_idx = 4'd5; step("R5 ack");
        idle(); step("R5 cleared");
        chk("R5 cleared", master_any, 0);

        // R6/R7/R9: deferred error
        att_set = 16'h0008; step("R9 prep");
        idle(); err_set = 16'h0008; etype_set = 4'b0010; step("R6 err set");
        idle(); step("R9 no trap");
        chk("R6 no hit without cmd", error_hit, 0);
        chk("R9 winner kept", win_idx, 3);
        cmd_valid = 1; cmd_idx = 4'd2; step("R7 other ctrl");
        cmd_idx = 4'd3; #1; chk("R6 hit on cmd", error_hit, 1);
        err_set = 16'h0008; step("R7 consume with reset");
        idle(); cmd_valid = 1; cmd_idx = 4'd3; #1;
        chk("R7 set kept over consume", error_hit, 1);
        step("R7 consume");
        idle(); cmd_valid = 1; cmd_idx = 4'd3; step("R7 consumed");

        // R8: class clear, set wins
        idle(); etype_clr = 4'b0011; etype_set = 4'b0001; step("R8 clr/set");
        idle(); step("R8 after");
        chk("R8 class value", err_class, 4'b0001);

        // Mixed sweep
        for (int n = 0; n < 600; n++) begin
            idle();
            att_set   = NC'($urandom) & NC'($urandom) & NC'($urandom);
            err_set   = (($urandom % 5) == 0) ? NC'(1 << ($urandom % NC)) : '0;
            ack_valid = ($urandom % 2) == 0;
            ack_idx   = ($urandom % 3 == 0) ? 4'($urandom) : win_idx;
            cmd_valid = ($urandom % 2) == 0;
            cmd_idx   = 4'(n);
            etype_set = (($urandom % 7) == 0) ? 4'($urandom) : '0;
            etype_clr = (($urandom % 5) == 0) ? 4'($urandom) : '0;
            step("R9 sweep");
        end
        idle(); step("end");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule